// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Line Buffer

This block sits between a memory fetch engine and a pixel pipeline that run on unrelated clocks. The fill side writes one video line at a time into one half of a dual-port RAM. Refresh and other stalls make the fill rate irregular, so the fill side is allowed to pause between pixels. The drain side reads the opposite half at a steady pixel rate and passes each word on to a colour decoder.

The RAM holds two line slots. The lower slot starts at word 0 and the upper slot starts at word 1024. Each side keeps its own slot selector and flips it when it completes a line. Line-complete events cross between the clock domains as toggle signals, each passed through a two-flop synchronizer. From those events each domain keeps its own count of occupied slots.

The fill side is held off when it would overwrite a slot the drain side has not yet finished with. If the drain side begins a line before any complete line is waiting, it raises a sticky underrun flag. It still streams that line, but it does not give up its slot.

Top module: `lineBufferPingPong`

## Requirements
- R1: While either reset is asserted, and immediately after reset, wrReady is 1, rdValid is 0 and rdUnderrun is 0.
- R2: Each rising wrClk edge with wrEn and wrReady both high stores wrData at the next pixel position of the current fill slot. After LINE_PIXELS (800) accepted pixels, the line is complete and filling moves to the other slot. The lower slot is at word 0 and the upper slot at word 1024.
- R3: When two completed lines are waiting and neither has been released, wrReady is 0. A write presented while wrReady is 0 changes nothing in the buffer.
- R4: If rdStart is sampled high on a rdClk edge while no line is streaming, a line starts. rdValid is then high on exactly the next LINE_PIXELS consecutive rdClk edges and low after them.
- R5: rdData carries the pixels of a line in the order they were written. Lines are read in the order they were completed, alternating between the two slots.
- R6: rdStart sampled while a line is streaming is ignored. It neither restarts nor lengthens the line.
- R7: When the drain side finishes a line that was complete, that slot is released. wrReady returns to 1 within 8 wrClk cycles of the last rdValid.
- R8: If rdStart begins a line while no complete line is waiting (this includes a fill still in progress), rdUnderrun goes to 1 and stays at 1 until rdRstN. Such a line still streams for LINE_PIXELS cycles, but it releases no slot, so the next line is read from the same slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Fill-side clock (100 MHz class) |
| wrRstN | input | 1 | Fill-side asynchronous reset, active low |
| wrEn | input | 1 | Pixel write request |
| wrData | input | DATA_W | Pixel word to store |
| wrReady | output | 1 | A slot is free for filling; writes are accepted only while high |
| rdClk | input | 1 | Pixel clock of the drain side |
| rdRstN | input | 1 | Drain-side asynchronous reset, active low |
| rdStart | input | 1 | Begin streaming one line |
| rdValid | output | 1 | rdData holds a pixel of the current line |
| rdData | output | DATA_W | Pixel word read from the buffer |
| rdUnderrun | output | 1 | Sticky: a line began with no complete line waiting |

## Verification
Two states are hard to reach from the ports. The first is the full state: two completed lines waiting, wrReady low, and further writes ignored. The bench reaches it by filling two lines before any read, then holds wrEn high with a marker value before draining. The second is an underrun that lands in the middle of a fill. The bench forks a read start into a fill that is already running. A concurrent phase with random write gaps then lets the two clocks interleave freely while the release handshake governs progress.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic wrStrobe;
    logic wrHalf;
    logic rdStrobe;
    logic rdHalf;
  } lbCmd_t;
endpackage

// File: rtl/lbSync.sv
module lbSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= d;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lbCtrl.sv
module lbCtrl import lbuf_pkg::*; #(
  parameter int LINE_PIXELS = 800,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W = $clog2(LINE_PIXELS)
) (
  input  logic             wrClk,
  input  logic             wrRstN,
  input  logic             wrEn,
  output logic             wrReady,
  output logic [PTR_W-1:0] wrPtr,
  input  logic             rdClk,
  input  logic             rdRstN,
  input  logic             rdStart,
  output logic             rdUnderrun,
  output logic [PTR_W-1:0] rdPtr,
  output lbCmd_t           cmd
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(LINE_PIXELS - 1);

  // ---------------- fill domain ----------------
  logic       wrHalf, fillTgl, relSync, relSyncD, relPulse;
  logic [1:0] wrOcc;
  logic       relTgl;
  logic       wrAccept, wrLineEnd;

  lbSync #(.STAGES(SYNC_STAGES)) i_relSync (
    .clk(wrClk), .rstN(wrRstN), .d(relTgl), .q(relSync));

  assign relPulse  = relSync ^ relSyncD;
  assign wrReady   = (wrOcc < 2'd2);
  assign wrAccept  = wrEn && wrReady;
  assign wrLineEnd = wrAccept && (wrPtr == LAST);

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrPtr    <= '0;
      wrHalf   <= 1'b0;
      fillTgl  <= 1'b0;
      wrOcc    <= '0;
      relSyncD <= 1'b0;
    end else begin
      relSyncD <= relSync;
      if (wrAccept) wrPtr <= wrLineEnd ? '0 : wrPtr + 1'b1;
      if (wrLineEnd) begin
        wrHalf  <= ~wrHalf;
        fillTgl <= ~fillTgl;
      end
      case ({wrLineEnd, relPulse})
        2'b10:   wrOcc <= wrOcc + 2'd1;
        2'b01:   wrOcc <= wrOcc - 2'd1;
        default: wrOcc <= wrOcc;
      endcase
    end
  end

  // ---------------- drain domain ----------------
  logic       fillSync, fillSyncD, fillPulse;
  logic [1:0] rdAvail;
  logic       rdActive, rdHalf, rdStale;
  logic       rdBegin, rdLineEnd, rdRelease;

  lbSync #(.STAGES(SYNC_STAGES)) i_fillSync (
    .clk(rdClk), .rstN(rdRstN), .d(fillTgl), .q(fillSync));

  assign fillPulse = fillSync ^ fillSyncD;
  assign rdBegin   = rdStart && !rdActive;
  assign rdLineEnd = rdActive && (rdPtr == LAST);
  assign rdRelease = rdLineEnd && !rdStale;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      fillSyncD  <= 1'b0;
      rdAvail    <= '0;
      rdActive   <= 1'b0;
      rdPtr      <= '0;
      rdHalf     <= 1'b0;
      rdStale    <= 1'b0;
      relTgl     <= 1'b0;
      rdUnderrun <= 1'b0;
    end else begin
      fillSyncD <= fillSync;
      if (rdBegin) begin
        rdActive <= 1'b1;
        rdPtr    <= '0;
        rdStale  <= (rdAvail == 2'd0);
        if (rdAvail == 2'd0) rdUnderrun <= 1'b1;
      end else if (rdActive) begin
        rdPtr <= rdLineEnd ? '0 : rdPtr + 1'b1;
        if (rdLineEnd) rdActive <= 1'b0;
      end
      if (rdRelease) begin
        rdHalf <= ~rdHalf;
        relTgl <= ~relTgl;
      end
      case ({fillPulse, rdRelease})
        2'b10:   rdAvail <= rdAvail + 2'd1;
        2'b01:   rdAvail <= rdAvail - 2'd1;
        default: rdAvail <= rdAvail;
      endcase
    end
  end

  always_comb begin
    cmd.wrStrobe = wrAccept;
    cmd.wrHalf   = wrHalf;
    cmd.rdStrobe = rdActive;
    cmd.rdHalf   = rdHalf;
  end
endmodule

// File: rtl/lbDatapath.sv
module lbDatapath import lbuf_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2048,
  parameter int PTR_W  = 10
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  lbCmd_t            cmd,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int AW      = $clog2(DEPTH);
  localparam int HALF_AW = AW - 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrAddr, rdAddr;

  assign wrAddr = {cmd.wrHalf, HALF_AW'(wrPtr)};
  assign rdAddr = {cmd.rdHalf, HALF_AW'(rdPtr)};

  always_ff @(posedge wrClk)
    if (cmd.wrStrobe) mem[wrAddr] <= wrData;

  always_ff @(posedge rdClk)
    if (cmd.rdStrobe) rdData <= mem[rdAddr];

  always_ff @(posedge rdClk or negedge rdRstN)
    if (!rdRstN) rdValid <= 1'b0;
    else         rdValid <= cmd.rdStrobe;
endmodule

// File: rtl/lineBufferPingPong.sv
module lineBufferPingPong import lbuf_pkg::*; #(
  parameter int DATA_W      = 16,
  parameter int DEPTH       = 2048,
  parameter int LINE_PIXELS = 800,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrReady,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdStart,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdUnderrun
);
  localparam int PTR_W = $clog2(LINE_PIXELS);

  lbCmd_t           cmd;
  logic [PTR_W-1:0] wrPtr, rdPtr;

  lbCtrl #(.LINE_PIXELS(LINE_PIXELS), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrReady(wrReady), .wrPtr(wrPtr),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdStart(rdStart), .rdUnderrun(rdUnderrun),
    .rdPtr(rdPtr), .cmd(cmd));

  lbDatapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) i_dp (
    .wrClk(wrClk), .rdClk(rdClk), .rdRstN(rdRstN), .cmd(cmd),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid));
endmodule

// File: rtl/lbChecker.sv
module lbChecker #(
  parameter int LINE_PIXELS = 800
) (
  input logic wrClk,
  input logic wrRstN,
  input logic wrEn,
  input logic wrReady,
  input logic rdClk,
  input logic rdRstN,
  input logic rdStart,
  input logic rdValid,
  input logic rdUnderrun
);
  localparam int RUN_W = $clog2(LINE_PIXELS + 1) + 1;
  logic [RUN_W-1:0] runCnt;

  always_ff @(posedge rdClk or negedge rdRstN)
    if (!rdRstN)      runCnt <= '0;
    else if (rdValid) runCnt <= runCnt + 1'b1;
    else              runCnt <= '0;

  assert_reset_quiet_R1: assert property (@(posedge rdClk)
    !rdRstN |=> (!rdValid && !rdUnderrun));

  assert_ready_fall_R3: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $fell(wrReady) |-> $past(wrEn));

  assert_run_length_R4: assert property (@(posedge rdClk) disable iff (!rdRstN)
    runCnt <= RUN_W'(LINE_PIXELS));

  assert_underrun_sticky_R8: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdUnderrun |=> rdUnderrun);

  assert_underrun_cause_R8: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $rose(rdUnderrun) |-> $past(rdStart));
endmodule

bind lineBufferPingPong lbChecker #(.LINE_PIXELS(LINE_PIXELS)) i_lbChecker (
  .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrReady(wrReady),
  .rdClk(rdClk), .rdRstN(rdRstN), .rdStart(rdStart), .rdValid(rdValid),
  .rdUnderrun(rdUnderrun));

// File: tb/test_lineBufferPingPong.sv
module test_lineBufferPingPong;
  localparam int DATA_W = 16;
  localparam int LINE   = 800;

  logic              wrClk = 1'b0, rdClk = 1'b0;
  logic              wrRstN = 1'b0, rdRstN = 1'b0;
  logic              wrEn = 1'b0, rdStart = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic              wrReady, rdValid, rdUnderrun;
  logic [DATA_W-1:0] rdData;

  int errors = 0, checks = 0;
  int filledN = 0;
  int salts [6];

  always #5  wrClk = ~wrClk;   // fill side, 100 MHz
  always #10 rdClk = ~rdClk;   // pixel side, 50 MHz

  lineBufferPingPong #(.DATA_W(DATA_W), .DEPTH(2048), .LINE_PIXELS(LINE)) i_lineBufferPingPong (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData), .wrReady(wrReady),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdStart(rdStart), .rdValid(rdValid),
    .rdData(rdData), .rdUnderrun(rdUnderrun));

  function automatic logic [DATA_W-1:0] expPix(input int salt, input int idx);
    int v;
    v = (salt * 40503) ^ (idx * 13) ^ (idx << 7);
    return DATA_W'(v);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    wrEn = 1'b0; rdStart = 1'b0;
    wrRstN = 1'b0; rdRstN = 1'b0;
    repeat (4) @(negedge rdClk);
    check(wrReady == 1'b1, "R1 wrReady in reset", wrReady, 1);
    check(rdValid == 1'b0 && rdUnderrun == 1'b0, "R1 rd outputs in reset",
          {rdValid, rdUnderrun}, 0);
    wrRstN = 1'b1; rdRstN = 1'b1;
    repeat (2) @(negedge rdClk);
  endtask

  // R2: writes one line, pausing when not ready or at random gaps
  task automatic fillLine(input int salt, input bit gaps);
    int i = 0;
    while (i < LINE) begin
      @(negedge wrClk);
      if (gaps && ($urandom % 4 == 0)) wrEn = 1'b0;
      else if (wrReady) begin
        wrEn = 1'b1; wrData = expPix(salt, i); i++;
      end else wrEn = 1'b0;
    end
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  task automatic readLine(input bit good, input int salt, input bit restart, input string tag);
    int nValid = 0, bad = 0, timingBad = 0, badAct = 0, badExp = 0;
    @(negedge rdClk); rdStart = 1'b1;
    @(negedge rdClk); rdStart = 1'b0;
    for (int c = 0; c < LINE + 2; c++) begin
      @(negedge rdClk);
      if (rdValid != (c < LINE)) timingBad++;
      if (rdValid) begin
        if (good && rdData != expPix(salt, nValid)) begin
          if (bad == 0) begin badAct = rdData; badExp = expPix(salt, nValid); end
          bad++;
        end
        nValid++;
      end
      rdStart = restart && (c == 100);
    end
    rdStart = 1'b0;
    check(timingBad == 0, {"R4 valid window ", tag}, nValid, LINE);
    if (good) check(bad == 0, {"R5 line data ", tag}, badAct, badExp);
    if (restart) check(nValid == LINE, "R6 restart ignored", nValid, LINE);
  endtask

  task automatic waitReady(input string tag);
    int n = 0;
    while (!wrReady && n < 8) begin @(negedge wrClk); n++; end
    check(wrReady == 1'b1, {"R7 release ", tag}, n, 8);
  endtask

  task automatic runAll();
    // ---- underrun with empty buffer, then data from same slot
    doReset();
    readLine(1'b0, 0, 1'b0, "underrun empty");
    check(rdUnderrun == 1'b1, "R8 underrun on empty start", rdUnderrun, 1);
    check(wrReady == 1'b1, "R8 stale line holds no slot", wrReady, 1);
    fillLine(11, 1'b0);
    repeat (6) @(negedge rdClk);
    readLine(1'b1, 11, 1'b0, "after underrun");
    check(rdUnderrun == 1'b1, "R8 underrun sticky", rdUnderrun, 1);

    // ---- full buffer: two lines waiting, writes ignored
    doReset();
    fillLine(21, 1'b0);
    fillLine(22, 1'b0);
    @(negedge wrClk);
    check(wrReady == 1'b0, "R3 ready low when two lines wait", wrReady, 0);
    for (int k = 0; k < 40; k++) begin
      @(negedge wrClk); wrEn = 1'b1; wrData = 16'hBEEF;
    end
    @(negedge wrClk); wrEn = 1'b0;
    check(wrReady == 1'b0, "R3 ready stays low", wrReady, 0);
    repeat (6) @(negedge rdClk);
    readLine(1'b1, 21, 1'b1, "R3 first line intact");
    waitReady("after first line");
    fillLine(23, 1'b1);
    repeat (6) @(negedge rdClk);
    readLine(1'b1, 22, 1'b0, "R5 second slot");
    readLine(1'b1, 23, 1'b0, "R5 back to first slot");
    check(rdUnderrun == 1'b0, "R8 no underrun when fed", rdUnderrun, 0);

    // ---- concurrent random phase
    doReset();
    fork
      begin
        for (int k = 0; k < 6; k++) begin
          salts[k] = int'($urandom);
          fillLine(salts[k], 1'b1);
          filledN++;
        end
      end
      begin
        for (int k = 0; k < 6; k++) begin
          wait (filledN > k);
          repeat (6) @(negedge rdClk);
          readLine(1'b1, salts[k], 1'b0, "R5 random");
        end
      end
    join
    check(rdUnderrun == 1'b0, "R8 no underrun in random run", rdUnderrun, 0);
    waitReady("end of random run");

    // ---- underrun while fill in progress
    doReset();
    fork
      fillLine(31, 1'b0);
      begin
        repeat (50) @(negedge rdClk);
        readLine(1'b0, 0, 1'b0, "underrun mid-fill");
      end
    join
    check(rdUnderrun == 1'b1, "R8 underrun mid-fill", rdUnderrun, 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    fork
      runAll();
      begin
        repeat (150000) @(posedge rdClk);
        errors++; checks++;
        $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule